// File: doc/BRIEF.md
# DRAM Rank Command Timing Tracker

This block follows the state of every bank in one DRAM rank and answers, in every cycle, one question: may the command presented on the request inputs be issued now? A scheduler places a command code, a bank number and a row on the request port. It reads the combinational `legal` answer. In the same cycle it raises `issue` if it sends the command. Only a command that is both legal and strobed changes the tracker's state. All minimum spacings are parameters counted in controller clock cycles. The defaults describe an 800 MHz part.

Internally each bank keeps three countdown timers: the next activate, the next column access and the next precharge. The rank keeps shared timers for activate-to-activate spacing, column-to-column spacing, both bus turnarounds and the refresh busy period. A small set of slot timers forms a rolling window that bounds how many activates fall inside any window of T_FAW cycles. Every timer counts down to zero and stops there. A timer is reloaded only on an issued command, and it takes the larger of its remaining count and the new spacing. A command is therefore legal only when all the waits that apply to it have run out. A refresh interval counter raises `refresh_due`.

Top module: `dram_rank_timer`

## Requirements
- R1: During reset all banks become closed and `refresh_due` goes low. In the first cycle after reset, an activate to any bank is legal.
- R2: An activate (`req_cmd` 1) is legal only to a closed bank. It must be at least T_RC (39) cycles after that bank's previous activate and at least T_RP (11) cycles after a precharge that closed it. Once issued, the bank reads as open in `bank_open[b]`, and its row appears at `open_row[b*ROW_W +: ROW_W]` from the next cycle.
- R3: Activates to any banks of the rank are at least T_RRD (5) cycles apart. At most four activates issue within any T_FAW (32) cycle window.
- R4: A column read (`req_cmd` 2) or write (3) is legal only to an open bank whose open row equals `req_row`. It must be at least T_RCD (11) cycles after that bank's activate and at least T_CCD (4) cycles after any column command.
- R5: A read must follow a write by at least T_CWD+T_BURST+T_WTR (15) cycles. A write must follow a read by at least T_CAS+T_BURST+T_RTRS−T_CWD (12) cycles.
- R6: A precharge (`req_cmd` 0) to a closed bank is always legal and has no effect. For an open bank, a precharge must be at least T_RAS (28) cycles after its activate, T_RTP (6) after its last read and T_CWD+T_BURST+T_WR (21) after its last write. Once issued, it closes the bank.
- R7: A precharge-all (`req_cmd` 5) is legal when every open bank meets the R6 limits. Once issued, it closes every bank.
- R8: A refresh (`req_cmd` 4) is legal only when all banks are closed and T_RP has passed since each was closed. Once it issues, no command of any kind is legal for T_RFC (128) cycles.
- R9: `refresh_due` goes high T_REFI (6240) cycles after reset or after the last issued refresh. It goes low in the cycle after a refresh issues.
- R10: Codes 6 and 7 are never legal. Raising `issue` while `legal` is low leaves the bank state unchanged.
- R11: When several spacings apply to one command, it becomes legal only after the longest remaining one. For example, a precharge after activate, read and write waits for the write recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row for activate and for the column row check |
| issue | input | 1 | The presented command is sent this cycle |
| legal | output | 1 | The presented command meets every timing rule now |
| bank_open | output | NB | One bit per bank, high while a row is open |
| open_row | output | NB*ROW_W | Open row of each bank, packed by bank number |
| refresh_due | output | 1 | The refresh interval has elapsed |

## Verification
A scripted command sequence probes each spacing one cycle before and exactly at its limit. Each probe tells a correct limit apart from one that is a cycle too long or too short. Some sequences stack several constraints on one command, such as a precharge after activate, read and write, or a refresh after a precharge-all. These show that the longest wait wins, rather than the first or the last one loaded. Column commands with the wrong row, and to a closed bank, separate the row check from the timer checks. A burst of activates across five banks separates the activate-to-activate spacing from the four-activate window. Strobes on illegal commands and a long idle run to the refresh interval cover state that must not move and the refresh flag.

// File: rtl/dram_timing_pkg.sv
package dram_timing_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_PRE  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_REF  = 3'd4,
    CMD_PREA = 3'd5
  } cmd_e;
endpackage

// File: rtl/dram_bank_state.sv
// Per-bank open row and the three countdowns gating activate, column and precharge.
module dram_bank_state #(
  parameter int TW     = 8,
  parameter int ROW_W  = 14,
  parameter int T_RCD  = 11,
  parameter int T_RP   = 11,
  parameter int T_RAS  = 28,
  parameter int T_RC   = 39,
  parameter int T_RTP  = 6,
  parameter int T_WPRE = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_act,
  input  logic             do_rd,
  input  logic             do_wr,
  input  logic             do_pre,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q,
  output logic             act_rdy,
  output logic             col_rdy,
  output logic             pre_rdy
);
  localparam logic [TW-1:0] L_RCD  = TW'(T_RCD - 1);
  localparam logic [TW-1:0] L_RP   = TW'(T_RP - 1);
  localparam logic [TW-1:0] L_RAS  = TW'(T_RAS - 1);
  localparam logic [TW-1:0] L_RC   = TW'(T_RC - 1);
  localparam logic [TW-1:0] L_RTP  = TW'(T_RTP - 1);
  localparam logic [TW-1:0] L_WPRE = TW'(T_WPRE - 1);

  function automatic logic [TW-1:0] tmr_next(input logic [TW-1:0] cur,
                                             input logic ld,
                                             input logic [TW-1:0] val);
    logic [TW-1:0] dec;
    dec = (cur != '0) ? cur - 1'b1 : '0;
    return (ld && (val > dec)) ? val : dec;
  endfunction

  logic [TW-1:0] act_t, col_t, pre_t;
  logic          close_now;
  logic [TW-1:0] act_val, pre_val;

  assign close_now = do_pre & is_open;
  assign act_val   = do_act ? L_RC : L_RP;
  assign pre_val   = do_act ? L_RAS : (do_wr ? L_WPRE : L_RTP);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_t   <= '0;
      col_t   <= '0;
      pre_t   <= '0;
      is_open <= 1'b0;
      row_q   <= '0;
    end else begin
      act_t <= tmr_next(act_t, do_act | close_now, act_val);
      col_t <= tmr_next(col_t, do_act, L_RCD);
      pre_t <= tmr_next(pre_t, do_act | do_rd | do_wr, pre_val);
      if (do_act) begin
        is_open <= 1'b1;
        row_q   <= row_in;
      end else if (do_pre) begin
        is_open <= 1'b0;
      end
    end
  end

  assign act_rdy = (act_t == '0);
  assign col_rdy = (col_t == '0);
  assign pre_rdy = (pre_t == '0);
endmodule

// File: rtl/dram_act_window.sv
// Rank-wide activate spacing plus a rolling window of recent activates.
module dram_act_window #(
  parameter int TW       = 8,
  parameter int T_RRD    = 5,
  parameter int T_FAW    = 32,
  parameter int WIN_ACTS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic act_go,
  output logic act_rdy
);
  localparam int SW = (WIN_ACTS > 1) ? $clog2(WIN_ACTS) : 1;
  localparam int CW = $clog2(WIN_ACTS + 1);
  localparam logic [TW-1:0] L_RRD = TW'(T_RRD - 1);
  localparam logic [TW-1:0] L_FAW = TW'(T_FAW - 1);

  logic [TW-1:0] rrd_t;
  logic [TW-1:0] slot_t [WIN_ACTS];
  logic [SW-1:0] free_idx;
  logic [CW-1:0] busy_cnt;

  always_comb begin
    free_idx = '0;
    busy_cnt = '0;
    for (int i = WIN_ACTS - 1; i >= 0; i--) begin
      if (slot_t[i] == '0) free_idx = SW'(i);
      else                 busy_cnt = busy_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              rrd_t <= '0;
    else if (act_go)      rrd_t <= L_RRD;
    else if (rrd_t != '0) rrd_t <= rrd_t - 1'b1;
  end

  for (genvar g = 0; g < WIN_ACTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                  slot_t[g] <= '0;
      else if (act_go && (free_idx == SW'(g))) slot_t[g] <= L_FAW;
      else if (slot_t[g] != '0)                 slot_t[g] <= slot_t[g] - 1'b1;
    end
  end

  assign act_rdy = (rrd_t == '0) && (busy_cnt < CW'(WIN_ACTS));
endmodule

// File: rtl/dram_col_spacing.sv
// Column-to-column spacing and the two data bus turnarounds.
module dram_col_spacing #(
  parameter int TW    = 8,
  parameter int T_CCD = 4,
  parameter int T_W2R = 15,
  parameter int T_R2W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_go,
  input  logic wr_go,
  output logic rd_rdy,
  output logic wr_rdy
);
  localparam logic [TW-1:0] L_CCD = TW'(T_CCD - 1);
  localparam logic [TW-1:0] L_W2R = TW'(T_W2R - 1);
  localparam logic [TW-1:0] L_R2W = TW'(T_R2W - 1);

  logic [TW-1:0] ccd_t, w2r_t, r2w_t;

  always_ff @(posedge clk) begin
    if (rst) begin
      ccd_t <= '0;
      w2r_t <= '0;
      r2w_t <= '0;
    end else begin
      if (rd_go | wr_go)    ccd_t <= L_CCD;
      else if (ccd_t != '0) ccd_t <= ccd_t - 1'b1;
      if (wr_go)            w2r_t <= L_W2R;
      else if (w2r_t != '0) w2r_t <= w2r_t - 1'b1;
      if (rd_go)            r2w_t <= L_R2W;
      else if (r2w_t != '0) r2w_t <= r2w_t - 1'b1;
    end
  end

  assign rd_rdy = (ccd_t == '0) && (w2r_t == '0);
  assign wr_rdy = (ccd_t == '0) && (r2w_t == '0);
endmodule

// File: rtl/dram_rank_timer.sv
// Legality checker for commands to one DRAM rank.
module dram_rank_timer
  import dram_timing_pkg::*;
#(
  parameter int NB       = 8,
  parameter int ROW_W    = 14,
  parameter int TW       = 8,
  parameter int T_RCD    = 11,
  parameter int T_RP     = 11,
  parameter int T_CAS    = 11,
  parameter int T_RAS    = 28,
  parameter int T_RC     = 39,
  parameter int T_RRD    = 5,
  parameter int T_FAW    = 32,
  parameter int FAW_ACTS = 4,
  parameter int T_WR     = 12,
  parameter int T_WTR    = 6,
  parameter int T_RTP    = 6,
  parameter int T_CCD    = 4,
  parameter int T_RFC    = 128,
  parameter int T_REFI   = 6240,
  parameter int T_CWD    = 5,
  parameter int T_RTRS   = 2,
  parameter int T_BURST  = 4,
  localparam int BANK_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CMD_W-1:0]      req_cmd,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [ROW_W-1:0]      req_row,
  input  logic                  issue,
  output logic                  legal,
  output logic [NB-1:0]         bank_open,
  output logic [NB*ROW_W-1:0]   open_row,
  output logic                  refresh_due
);
  localparam int REFI_W = $clog2(T_REFI + 1);
  localparam int T_WPRE = T_CWD + T_BURST + T_WR;
  localparam int T_W2R  = T_CWD + T_BURST + T_WTR;
  localparam int T_R2W  = T_CAS + T_BURST + T_RTRS - T_CWD;
  localparam logic [TW-1:0]     L_RFC  = TW'(T_RFC - 1);
  localparam logic [REFI_W-1:0] L_REFI = REFI_W'(T_REFI - 1);

  logic             go;
  logic             is_pre, is_act, is_rd, is_wr, is_ref, is_prea;
  logic [NB-1:0]    b_act_rdy, b_col_rdy, b_pre_rdy, b_open;
  logic [ROW_W-1:0] row_arr [NB];
  logic             win_rdy, rd_rdy, wr_rdy;
  logic [TW-1:0]    rfc_t;
  logic [REFI_W-1:0] refi_cnt;
  logic             bank_ok, sel_open, row_hit, cmd_ok;

  assign go      = issue & legal;
  assign is_pre  = (req_cmd == CMD_PRE);
  assign is_act  = (req_cmd == CMD_ACT);
  assign is_rd   = (req_cmd == CMD_RD);
  assign is_wr   = (req_cmd == CMD_WR);
  assign is_ref  = (req_cmd == CMD_REF);
  assign is_prea = (req_cmd == CMD_PREA);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic hit;
    assign hit = (req_bank == BANK_W'(g));
    dram_bank_state #(
      .TW(TW), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
      .T_RC(T_RC), .T_RTP(T_RTP), .T_WPRE(T_WPRE)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .do_act (go & is_act & hit),
      .do_rd  (go & is_rd & hit),
      .do_wr  (go & is_wr & hit),
      .do_pre (go & ((is_pre & hit) | is_prea)),
      .row_in (req_row),
      .is_open(b_open[g]),
      .row_q  (row_arr[g]),
      .act_rdy(b_act_rdy[g]),
      .col_rdy(b_col_rdy[g]),
      .pre_rdy(b_pre_rdy[g])
    );
    assign open_row[g*ROW_W +: ROW_W] = row_arr[g];
  end

  dram_act_window #(
    .TW(TW), .T_RRD(T_RRD), .T_FAW(T_FAW), .WIN_ACTS(FAW_ACTS)
  ) u_win (
    .clk    (clk),
    .rst    (rst),
    .act_go (go & is_act),
    .act_rdy(win_rdy)
  );

  dram_col_spacing #(
    .TW(TW), .T_CCD(T_CCD), .T_W2R(T_W2R), .T_R2W(T_R2W)
  ) u_col (
    .clk   (clk),
    .rst   (rst),
    .rd_go (go & is_rd),
    .wr_go (go & is_wr),
    .rd_rdy(rd_rdy),
    .wr_rdy(wr_rdy)
  );

  // Refresh busy window and refresh interval.
  always_ff @(posedge clk) begin
    if (rst) begin
      rfc_t    <= '0;
      refi_cnt <= L_REFI;
    end else begin
      if (go && is_ref)        rfc_t <= L_RFC;
      else if (rfc_t != '0)    rfc_t <= rfc_t - 1'b1;
      if (go && is_ref)        refi_cnt <= L_REFI;
      else if (refi_cnt != '0) refi_cnt <= refi_cnt - 1'b1;
    end
  end

  assign bank_ok  = (int'(req_bank) < NB);
  assign sel_open = bank_ok && b_open[req_bank];
  assign row_hit  = bank_ok && (row_arr[req_bank] == req_row);

  always_comb begin
    case (req_cmd)
      CMD_ACT:  cmd_ok = bank_ok && !sel_open && b_act_rdy[req_bank] && win_rdy;
      CMD_RD:   cmd_ok = sel_open && row_hit && b_col_rdy[req_bank] && rd_rdy;
      CMD_WR:   cmd_ok = sel_open && row_hit && b_col_rdy[req_bank] && wr_rdy;
      CMD_PRE:  cmd_ok = bank_ok && (!sel_open || b_pre_rdy[req_bank]);
      CMD_PREA: cmd_ok = &(~b_open | b_pre_rdy);
      CMD_REF:  cmd_ok = (b_open == '0) && (&b_act_rdy);
      default:  cmd_ok = 1'b0;
    endcase
  end

  assign legal       = (rfc_t == '0) && cmd_ok;
  assign bank_open   = b_open;
  assign refresh_due = (refi_cnt == '0);
endmodule

// File: rtl/dram_rank_timer_chk.sv
module dram_rank_timer_chk #(
  parameter int NB     = 8,
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3,
  parameter int T_RRD  = 5,
  parameter int T_RFC  = 128
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          req_cmd,
  input logic [BANK_W-1:0]   req_bank,
  input logic [ROW_W-1:0]    req_row,
  input logic                issue,
  input logic                legal,
  input logic [NB-1:0]       bank_open,
  input logic [NB*ROW_W-1:0] open_row,
  input logic                refresh_due
);
  logic [15:0] since_act, since_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= '1;
      since_ref <= '1;
    end else begin
      if (issue && legal && req_cmd == 3'd1) since_act <= 16'd1;
      else if (since_act != '1)              since_act <= since_act + 1'b1;
      if (issue && legal && req_cmd == 3'd4) since_ref <= 16'd1;
      else if (since_ref != '1)              since_ref <= since_ref + 1'b1;
    end
  end

  a_r1_reset_closed: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_open == '0 && !refresh_due));

  a_r2_act_opens: assert property (@(posedge clk) disable iff (rst)
    (issue && legal && req_cmd == 3'd1) |=>
      (bank_open[$past(req_bank)] && open_row[$past(req_bank)*ROW_W +: ROW_W] == $past(req_row)));

  a_r3_rrd_gap: assert property (@(posedge clk) disable iff (rst)
    (legal && req_cmd == 3'd1) |-> (since_act >= 16'(T_RRD)));

  a_r4_col_open: assert property (@(posedge clk) disable iff (rst)
    (legal && (req_cmd == 3'd2 || req_cmd == 3'd3)) |-> bank_open[req_bank]);

  a_r6_pre_closes: assert property (@(posedge clk) disable iff (rst)
    (issue && legal && req_cmd == 3'd0) |=> !bank_open[$past(req_bank)]);

  a_r7_prea_closes: assert property (@(posedge clk) disable iff (rst)
    (issue && legal && req_cmd == 3'd5) |=> (bank_open == '0));

  a_r8_ref_closed: assert property (@(posedge clk) disable iff (rst)
    (legal && req_cmd == 3'd4) |-> (bank_open == '0));

  a_r8_ref_quiet: assert property (@(posedge clk) disable iff (rst)
    legal |-> (since_ref >= 16'(T_RFC)));

  a_r10_reserved: assert property (@(posedge clk) disable iff (rst)
    (req_cmd > 3'd5) |-> !legal);

  a_r10_ignored: assert property (@(posedge clk) disable iff (rst)
    (issue && !legal) |=> (bank_open == $past(bank_open)));
endmodule

bind dram_rank_timer dram_rank_timer_chk #(
  .NB(NB), .ROW_W(ROW_W), .BANK_W(BANK_W), .T_RRD(T_RRD), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst(rst), .req_cmd(req_cmd), .req_bank(req_bank), .req_row(req_row),
  .issue(issue), .legal(legal), .bank_open(bank_open), .open_row(open_row),
  .refresh_due(refresh_due)
);

// File: tb/dram_rank_timer_bench.sv
module dram_rank_timer_bench;
  localparam int REFI = 6240;
  localparam int NV   = 45;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   req_cmd = 3'd0;
  logic [2:0]   req_bank = 3'd0;
  logic [13:0]  req_row = '0;
  logic         issue = 1'b0;
  logic         legal;
  logic [7:0]   bank_open;
  logic [111:0] open_row;
  logic         refresh_due;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  dram_rank_timer #(.T_REFI(REFI)) u_dram_rank_timer (
    .clk(clk), .rst(rst), .req_cmd(req_cmd), .req_bank(req_bank), .req_row(req_row),
    .issue(issue), .legal(legal), .bank_open(bank_open), .open_row(open_row),
    .refresh_due(refresh_due)
  );

  typedef struct packed {
    logic [2:0] cmd;
    logic [2:0] bank;
    logic [3:0] row;
    logic       iss;
    logic [7:0] dly;
    logic       exp;
    logic [3:0] rq;
  } vec_t;

  // {cmd, bank, row, issue, idle cycles before, expected legal, requirement}
  // cmd codes: 0 PRE, 1 ACT, 2 RD, 3 WR, 4 REF, 5 PREA
  localparam logic [23:0] VEC [NV] = '{
    {3'd1,3'd0,4'd5,1'b1,8'd0,  1'b1,4'd1},  // t0   R1 first ACT
    {3'd1,3'd1,4'd7,1'b0,8'd2,  1'b0,4'd3},  // t3   R3 RRD
    {3'd1,3'd1,4'd7,1'b0,8'd0,  1'b0,4'd3},  // t4   R3
    {3'd1,3'd1,4'd7,1'b1,8'd0,  1'b1,4'd3},  // t5   R3 RRD met
    {3'd2,3'd0,4'd6,1'b0,8'd0,  1'b0,4'd4},  // t6   R4 wrong row
    {3'd2,3'd0,4'd5,1'b0,8'd3,  1'b0,4'd4},  // t10  R4 RCD
    {3'd2,3'd0,4'd5,1'b1,8'd0,  1'b1,4'd4},  // t11  R4
    {3'd2,3'd1,4'd7,1'b0,8'd0,  1'b0,4'd4},  // t12  R4 CCD
    {3'd2,3'd1,4'd7,1'b0,8'd2,  1'b0,4'd4},  // t15  R4 RCD b1
    {3'd2,3'd1,4'd7,1'b1,8'd0,  1'b1,4'd4},  // t16  R4
    {3'd3,3'd0,4'd5,1'b0,8'd0,  1'b0,4'd5},  // t17  R5 read-to-write
    {3'd3,3'd0,4'd5,1'b0,8'd9,  1'b0,4'd5},  // t27  R5
    {3'd3,3'd0,4'd5,1'b1,8'd0,  1'b1,4'd5},  // t28  R5
    {3'd2,3'd1,4'd7,1'b0,8'd0,  1'b0,4'd5},  // t29  R5 write-to-read
    {3'd2,3'd1,4'd7,1'b0,8'd12, 1'b0,4'd5},  // t42  R5
    {3'd2,3'd1,4'd7,1'b1,8'd0,  1'b1,4'd5},  // t43  R5
    {3'd0,3'd0,4'd0,1'b0,8'd0,  1'b0,4'd11}, // t44  R11 write recovery dominates
    {3'd0,3'd0,4'd0,1'b0,8'd3,  1'b0,4'd11}, // t48  R11
    {3'd0,3'd0,4'd0,1'b1,8'd0,  1'b1,4'd6},  // t49  R6
    {3'd1,3'd0,4'd9,1'b0,8'd0,  1'b0,4'd2},  // t50  R2 RP/RC
    {3'd1,3'd0,4'd9,1'b0,8'd8,  1'b0,4'd2},  // t59  R2
    {3'd1,3'd0,4'd9,1'b1,8'd0,  1'b1,4'd2},  // t60  R2
    {3'd0,3'd1,4'd0,1'b1,8'd0,  1'b1,4'd6},  // t61  R6 b1 close
    {3'd4,3'd0,4'd0,1'b0,8'd0,  1'b0,4'd8},  // t62  R8 bank open
    {3'd5,3'd0,4'd0,1'b0,8'd0,  1'b0,4'd7},  // t63  R7 RAS of b0
    {3'd5,3'd0,4'd0,1'b0,8'd23, 1'b0,4'd7},  // t87  R7
    {3'd5,3'd0,4'd0,1'b1,8'd0,  1'b1,4'd7},  // t88  R7
    {3'd4,3'd0,4'd0,1'b0,8'd0,  1'b0,4'd8},  // t89  R8 RP after PREA
    {3'd4,3'd0,4'd0,1'b0,8'd8,  1'b0,4'd8},  // t98  R8
    {3'd4,3'd0,4'd0,1'b1,8'd0,  1'b1,4'd8},  // t99  R8
    {3'd1,3'd2,4'd3,1'b0,8'd0,  1'b0,4'd8},  // t100 R8 busy
    {3'd1,3'd2,4'd3,1'b0,8'd125,1'b0,4'd8},  // t226 R8
    {3'd1,3'd2,4'd3,1'b1,8'd0,  1'b1,4'd8},  // t227 R8 RFC over
    {3'd1,3'd3,4'd1,1'b0,8'd3,  1'b0,4'd3},  // t231 R3
    {3'd1,3'd3,4'd1,1'b1,8'd0,  1'b1,4'd3},  // t232 R3
    {3'd1,3'd4,4'd2,1'b1,8'd4,  1'b1,4'd3},  // t237 R3
    {3'd1,3'd5,4'd4,1'b1,8'd4,  1'b1,4'd3},  // t242 R3 fourth
    {3'd1,3'd6,4'd8,1'b0,8'd4,  1'b0,4'd3},  // t247 R3 window full
    {3'd1,3'd6,4'd8,1'b0,8'd10, 1'b0,4'd3},  // t258 R3
    {3'd1,3'd6,4'd8,1'b1,8'd0,  1'b1,4'd3},  // t259 R3 window frees
    {3'd2,3'd2,4'd4,1'b0,8'd0,  1'b0,4'd4},  // t260 R4 row mismatch only
    {3'd2,3'd2,4'd3,1'b0,8'd0,  1'b1,4'd4},  // t261 R4 row hit
    {3'd2,3'd7,4'd0,1'b0,8'd0,  1'b0,4'd4},  // t262 R4 closed bank
    {3'd6,3'd0,4'd0,1'b0,8'd0,  1'b0,4'd10}, // t263 R10 reserved code
    {3'd0,3'd7,4'd0,1'b0,8'd0,  1'b1,4'd6}   // t264 R6 closed-bank PRE
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic present(input logic [2:0] c, input logic [2:0] b,
                         input logic [13:0] r, input logic iss);
    @(negedge clk);
    req_cmd = c; req_bank = b; req_row = r; issue = iss;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; issue = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    vec_t v;
    bit   hit;
    do_reset();
    req_cmd = 3'd1; req_bank = 3'd0; #1;
    // R1 reset state
    check(bank_open == 8'h00, "R1", "bank_open", bank_open, 0);
    check(!refresh_due, "R1", "refresh_due", refresh_due, 0);
    check(legal, "R1", "act legal", legal, 1);

    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VEC[i]);
      for (int k = 0; k < int'(v.dly); k++) idle();
      present(v.cmd, v.bank, {10'd0, v.row}, v.iss);
      check(legal == v.exp, $sformatf("R%0d", v.rq), $sformatf("vector %0d legal", i),
            legal, v.exp);
    end
    idle(); #1;

    // R2 open flags and rows after the activate burst
    check(bank_open == 8'h7C, "R2", "bank_open", bank_open, 8'h7C);
    check(open_row[6*14 +: 14] == 14'd8, "R2", "row b6", open_row[6*14 +: 14], 8);

    // R10 strobe on an illegal ACT to open bank 2 leaves state alone
    present(3'd1, 3'd2, 14'd1, 1'b1);
    check(!legal, "R10", "act to open bank", legal, 0);
    idle(); #1;
    check(open_row[2*14 +: 14] == 14'd3, "R10", "row b2", open_row[2*14 +: 14], 3);
    check(bank_open == 8'h7C, "R10", "bank_open", bank_open, 8'h7C);

    // R7 precharge-all once legal closes everything
    hit = 1'b0;
    for (int k = 0; k < 100 && !hit; k++) begin
      present(3'd5, 3'd0, 14'd0, 1'b0);
      if (legal) begin issue = 1'b1; hit = 1'b1; end
    end
    check(hit, "R7", "prea became legal", hit, 1);
    idle(); #1;
    check(bank_open == 8'h00, "R7", "bank_open after prea", bank_open, 0);

    // R9 refresh interval
    do_reset();
    repeat (REFI - 3) @(negedge clk);
    #1;
    check(!refresh_due, "R9", "due early", refresh_due, 0);
    repeat (4) @(negedge clk);
    #1;
    check(refresh_due, "R9", "due late", refresh_due, 1);
    present(3'd4, 3'd0, 14'd0, 1'b1);
    check(legal, "R8", "ref legal all closed", legal, 1);
    idle(); #1;
    check(!refresh_due, "R9", "due cleared", refresh_due, 0);
    // R8 even a closed-bank precharge waits out the refresh
    present(3'd0, 3'd1, 14'd0, 1'b0);
    check(!legal, "R8", "pre during refresh", legal, 0);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule